// File: doc/BRIEF.md
# Privilege-Segmented Virtual Address Decoder

This block sits at the front of address translation for a 32-bit virtual space. Every request is sorted into one of five fixed windows by its top address bits. The decoder then checks the caller's privilege level against the rules of that window. Two outcomes are possible. The request may be resolved here, with the physical address formed by fixed arithmetic. Otherwise it is handed to an external page-lookup unit through a request strobe, and that unit's physical address and status come back on the same cycle.

The decoder folds the window check and the lookup status into one fault class. From that class it picks the exception kind to raise and a refill flag. All of this is combinational.

Three fault-capture registers are loaded on a clock edge when a fault occurs and capture is enabled:
- the faulting address;
- a context word, made of a base field supplied from outside and a page-pair index;
- an entry-high word, made of the faulting page-pair number and the current address-space identifier.

Top module: `vseg_decoder`

## Requirements
- R1: With the error-level input high, an address below 0x80000000 resolves to itself as the physical address. It raises no lookup request and no fault, in every privilege mode.
- R2: With the error-level input low, an address below 0x80000000 raises the lookup request in every privilege mode. On a lookup hit (status 2'b00) the physical output equals the lookup's physical address.
- R3: Addresses 0x80000000 to 0x9FFFFFFF are for kernel only (mode 2'b00). In kernel mode the physical address is the address minus 0x80000000 and no lookup is requested. In any other mode (2'b01 supervisor; 2'b10 and 2'b11 user) the result is a bad-address fault.
- R4: Addresses 0xA0000000 to 0xBFFFFFFF are for kernel only. In kernel mode the physical address is the address minus 0xA0000000 and no lookup is requested. In any other mode the result is a bad-address fault.
- R5: Addresses 0xC0000000 to 0xDFFFFFFF go to the lookup in supervisor and kernel modes. In user mode they give a bad-address fault with no lookup request.
- R6: Addresses 0xE0000000 and above go to the lookup in kernel mode only. In any other mode they give a bad-address fault.
- R7: A bad-address fault gives exception kind 2 (address error, store) on a write and kind 1 (address error, load) on a read. The refill flag is 0. With no fault, the exception kind is 0.
- R8: Lookup status "no match" (2'b01) gives kind 4 (TLB store) on a write and kind 3 (TLB load) on a read, with the refill flag set.
- R9: Lookup status "invalid" (2'b10) gives kind 4 on a write and kind 3 on a read, with the refill flag clear.
- R10: Lookup status "dirty" (2'b11) gives kind 5 (TLB modify) on both reads and writes, with the refill flag clear.
- R11: On a clock edge where a fault is flagged and capture is enabled, three registers load. At every other edge they hold, and reset clears them to 0. The loaded values are:
  - bad address = the full address;
  - context = {context base[8:0], address[31:13], 4'b0000};
  - entry-high = {address[31:13], 5'b00000, identifier[7:0]}.
- R12: The lookup status has no effect on requests that resolve without the lookup. With the request-valid input low, there is no lookup request and no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A translation request is present |
| req_addr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = store access, 0 = load access |
| priv_mode | input | 2 | 00 kernel, 01 supervisor, 10/11 user |
| err_level | input | 1 | Error-level status: bypasses the low window |
| lk_req | output | 1 | Request to the page-lookup unit |
| lk_status | input | 2 | Lookup result: 00 hit, 01 no match, 10 invalid, 11 dirty |
| lk_paddr | input | 32 | Physical address from the lookup |
| phys_addr | output | 32 | Resulting physical address, meaningful when no fault |
| fault | output | 1 | Request faults |
| exc_kind | output | 3 | Exception kind code, 0 when none |
| refill | output | 1 | Fault came from a lookup miss |
| cap_en | input | 1 | Enables loading of the capture registers |
| ctx_base | input | 9 | Upper field placed into the context word |
| cur_asid | input | 8 | Current address-space identifier |
| bad_addr_q | output | 32 | Captured faulting address |
| context_q | output | 32 | Captured context word |
| entry_hi_q | output | 32 | Captured entry-high word |

## Verification
The lookup request, physical address, fault, exception kind and refill flag all depend on the inputs alone. They are due in the same cycle the inputs change. The bench therefore drives each stimulus just after a falling edge and samples a few nanoseconds later, before the next rising edge.

The three capture registers change only at a rising edge. They are checked at the following falling edge. Their hold behaviour is checked one full cycle later, after the inputs have moved to a different faulting address.

// File: rtl/vseg_pkg.sv
package vseg_pkg;

  localparam int VA_W   = 32;
  localparam int SEG_W  = 3;
  localparam int PG2_LO = 13;

  typedef enum logic [1:0] {
    PRIV_KERN = 2'b00,
    PRIV_SUP  = 2'b01,
    PRIV_USR  = 2'b10,
    PRIV_USR2 = 2'b11
  } priv_e;

  typedef enum logic [1:0] {
    LK_HIT     = 2'b00,
    LK_NOMATCH = 2'b01,
    LK_INVALID = 2'b10,
    LK_DIRTY   = 2'b11
  } lk_st_e;

  typedef enum logic [2:0] {
    FC_NONE    = 3'd0,
    FC_BADADDR = 3'd1,
    FC_NOMATCH = 3'd2,
    FC_INVALID = 3'd3,
    FC_DIRTY   = 3'd4
  } fclass_e;

  typedef enum logic [2:0] {
    EXC_NONE      = 3'd0,
    EXC_ADDR_LD   = 3'd1,
    EXC_ADDR_ST   = 3'd2,
    EXC_TLB_LD    = 3'd3,
    EXC_TLB_ST    = 3'd4,
    EXC_TLB_MOD   = 3'd5
  } exc_e;

  localparam logic [VA_W-1:0] UNC0_BASE = 32'h8000_0000;
  localparam logic [VA_W-1:0] UNC1_BASE = 32'hA000_0000;

endpackage

// File: rtl/vseg_classify.sv
module vseg_classify
  import vseg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid_i,
  input  logic [VA_W-1:0] addr_i,
  input  logic [1:0]      mode_i,
  input  logic            erl_i,
  output logic            need_map_o,
  output logic            direct_o,
  output logic [VA_W-1:0] direct_pa_o,
  output logic            bad_o
);

  logic [SEG_W-1:0] win;
  logic is_kern, is_sup;
  logic need_map_raw, direct_raw, bad_raw;

  assign win     = addr_i[VA_W-1 -: SEG_W];
  assign is_kern = (mode_i == PRIV_KERN);
  assign is_sup  = (mode_i == PRIV_SUP);

  always_comb begin
    need_map_raw = 1'b0;
    direct_raw   = 1'b0;
    bad_raw      = 1'b0;
    direct_pa_o  = addr_i;
    unique case (win)
      3'd0, 3'd1, 3'd2, 3'd3: begin
        if (erl_i) direct_raw   = 1'b1;
        else       need_map_raw = 1'b1;
      end
      3'd4: begin
        direct_pa_o = addr_i - UNC0_BASE;
        if (is_kern) direct_raw = 1'b1;
        else         bad_raw    = 1'b1;
      end
      3'd5: begin
        direct_pa_o = addr_i - UNC1_BASE;
        if (is_kern) direct_raw = 1'b1;
        else         bad_raw    = 1'b1;
      end
      3'd6: begin
        if (is_kern || is_sup) need_map_raw = 1'b1;
        else                   bad_raw      = 1'b1;
      end
      default: begin
        if (is_kern) need_map_raw = 1'b1;
        else         bad_raw      = 1'b1;
      end
    endcase
  end

  assign need_map_o = valid_i && need_map_raw;
  assign direct_o   = valid_i && direct_raw;
  assign bad_o      = valid_i && bad_raw;

  AST_USER_HIGH_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && addr_i[VA_W-1] && mode_i[1]) |-> (bad_o && !need_map_o)); // R5

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({need_map_o, direct_o, bad_o})); // R12

endmodule

// File: rtl/vseg_fault_merge.sv
module vseg_fault_merge
  import vseg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bad_i,
  input  logic       need_map_i,
  input  logic [1:0] lk_status_i,
  input  logic       write_i,
  output logic       fault_o,
  output logic [2:0] exc_o,
  output logic       refill_o
);

  fclass_e fc;

  always_comb begin
    fc = FC_NONE;
    if (bad_i) begin
      fc = FC_BADADDR;
    end else if (need_map_i) begin
      unique case (lk_st_e'(lk_status_i))
        LK_NOMATCH: fc = FC_NOMATCH;
        LK_INVALID: fc = FC_INVALID;
        LK_DIRTY:   fc = FC_DIRTY;
        default:    fc = FC_NONE;
      endcase
    end
  end

  always_comb begin
    exc_o    = EXC_NONE;
    refill_o = 1'b0;
    unique case (fc)
      FC_BADADDR: exc_o = write_i ? EXC_ADDR_ST : EXC_ADDR_LD;
      FC_NOMATCH: begin
        exc_o    = write_i ? EXC_TLB_ST : EXC_TLB_LD;
        refill_o = 1'b1;
      end
      FC_INVALID: exc_o = write_i ? EXC_TLB_ST : EXC_TLB_LD;
      FC_DIRTY:   exc_o = EXC_TLB_MOD;
      default:    exc_o = EXC_NONE;
    endcase
  end

  assign fault_o = (fc != FC_NONE);

  AST_KIND_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    fault_o == (exc_o != 3'd0)); // R7

  AST_REFILL_TLB_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    refill_o |-> (need_map_i && (exc_o == 3'd3 || exc_o == 3'd4))); // R8

  AST_BAD_IS_ADDR_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    bad_i |-> (exc_o == (write_i ? 3'd2 : 3'd1))); // R7

endmodule

// File: rtl/vseg_capture.sv
module vseg_capture
  import vseg_pkg::*;
#(
  parameter int ASID_W = 8,
  parameter int CBASE_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fault_i,
  input  logic               cap_en_i,
  input  logic [VA_W-1:0]    addr_i,
  input  logic [CBASE_W-1:0] ctx_base_i,
  input  logic [ASID_W-1:0]  asid_i,
  output logic [VA_W-1:0]    bad_addr_q,
  output logic [VA_W-1:0]    context_q,
  output logic [VA_W-1:0]    entry_hi_q
);

  localparam int PG2_W = VA_W - PG2_LO;
  localparam int CTX_PAD = VA_W - CBASE_W - PG2_W;
  localparam int EH_PAD = PG2_LO - ASID_W;

  logic            load;
  logic [VA_W-1:0] bad_d, ctx_d, eh_d;

  assign load = fault_i && cap_en_i;

  always_comb begin
    bad_d = bad_addr_q;
    ctx_d = context_q;
    eh_d  = entry_hi_q;
    if (load) begin
      bad_d = addr_i;
      ctx_d = {ctx_base_i, addr_i[VA_W-1:PG2_LO], {CTX_PAD{1'b0}}};
      eh_d  = {addr_i[VA_W-1:PG2_LO], {EH_PAD{1'b0}}, asid_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bad_addr_q <= '0;
      context_q  <= '0;
      entry_hi_q <= '0;
    end else begin
      bad_addr_q <= bad_d;
      context_q  <= ctx_d;
      entry_hi_q <= eh_d;
    end
  end

  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(load) |-> ($stable(bad_addr_q) && $stable(entry_hi_q))); // R11

  AST_CAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load && rst_n) |-> (bad_addr_q == $past(addr_i))); // R11

endmodule

// File: rtl/vseg_decoder.sv
module vseg_decoder
  import vseg_pkg::*;
#(
  parameter int ASID_W  = 8,
  parameter int CBASE_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [31:0]        req_addr,
  input  logic               req_write,
  input  logic [1:0]         priv_mode,
  input  logic               err_level,
  output logic               lk_req,
  input  logic [1:0]         lk_status,
  input  logic [31:0]        lk_paddr,
  output logic [31:0]        phys_addr,
  output logic               fault,
  output logic [2:0]         exc_kind,
  output logic               refill,
  input  logic               cap_en,
  input  logic [CBASE_W-1:0] ctx_base,
  input  logic [ASID_W-1:0]  cur_asid,
  output logic [31:0]        bad_addr_q,
  output logic [31:0]        context_q,
  output logic [31:0]        entry_hi_q
);

  logic            need_map, direct, bad;
  logic [VA_W-1:0] direct_pa;

  vseg_classify u_cls (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_i     (req_valid),
    .addr_i      (req_addr),
    .mode_i      (priv_mode),
    .erl_i       (err_level),
    .need_map_o  (need_map),
    .direct_o    (direct),
    .direct_pa_o (direct_pa),
    .bad_o       (bad)
  );

  vseg_fault_merge u_fm (
    .clk         (clk),
    .rst_n       (rst_n),
    .bad_i       (bad),
    .need_map_i  (need_map),
    .lk_status_i (lk_status),
    .write_i     (req_write),
    .fault_o     (fault),
    .exc_o       (exc_kind),
    .refill_o    (refill)
  );

  vseg_capture #(.ASID_W(ASID_W), .CBASE_W(CBASE_W)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .fault_i    (fault),
    .cap_en_i   (cap_en),
    .addr_i     (req_addr),
    .ctx_base_i (ctx_base),
    .asid_i     (cur_asid),
    .bad_addr_q (bad_addr_q),
    .context_q  (context_q),
    .entry_hi_q (entry_hi_q)
  );

  assign lk_req    = need_map;
  assign phys_addr = need_map ? lk_paddr : direct_pa;

  AST_UNMAPPED_NO_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
    (req_addr[31:30] == 2'b10) |-> !lk_req); // R3

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!lk_req && !fault)); // R12

  AST_ERL_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && err_level && !req_addr[31]) |-> (!fault && phys_addr == req_addr)); // R1

endmodule

// File: tb/vseg_decoder_tb.sv
module vseg_decoder_tb;

  logic        clk;
  logic        rst_n;
  logic        req_valid, req_write, err_level, cap_en;
  logic [31:0] req_addr, lk_paddr;
  logic [1:0]  priv_mode, lk_status;
  logic [8:0]  ctx_base;
  logic [7:0]  cur_asid;
  logic        lk_req, fault, refill;
  logic [31:0] phys_addr, bad_addr_q, context_q, entry_hi_q;
  logic [2:0]  exc_kind;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  vseg_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .priv_mode(priv_mode), .err_level(err_level),
    .lk_req(lk_req), .lk_status(lk_status), .lk_paddr(lk_paddr),
    .phys_addr(phys_addr), .fault(fault), .exc_kind(exc_kind), .refill(refill),
    .cap_en(cap_en), .ctx_base(ctx_base), .cur_asid(cur_asid),
    .bad_addr_q(bad_addr_q), .context_q(context_q), .entry_hi_q(entry_hi_q)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic sweep_one(input logic [31:0] a, input logic [1:0] pm, input bit el,
                           input bit wr, input logic [1:0] st);
    bit exp_map, exp_bad, exp_fault, exp_ref;
    logic [31:0] exp_pa;
    logic [2:0] exp_kind;
    string rq, rk;
    bit kern, sup;
    kern = (pm == 2'b00);
    sup  = (pm == 2'b01);
    exp_map = 0; exp_bad = 0; exp_pa = a;
    case (a[31:29])
      3'd4: begin rq = "R3"; exp_pa = a - 32'h8000_0000; exp_bad = !kern; end
      3'd5: begin rq = "R4"; exp_pa = a - 32'hA000_0000; exp_bad = !kern; end
      3'd6: begin rq = "R5"; exp_map = kern || sup; exp_bad = !(kern || sup); end
      3'd7: begin rq = "R6"; exp_map = kern; exp_bad = !kern; end
      default: begin
        if (el) rq = "R1"; else begin rq = "R2"; exp_map = 1; end
      end
    endcase
    if (exp_map) exp_pa = 32'h5A5A_0000 ^ a;
    exp_ref = 0; exp_kind = 3'd0;
    rk = "R7";
    if (exp_bad) exp_kind = wr ? 3'd2 : 3'd1;
    else if (exp_map) begin
      case (st)
        2'b01: begin rk = "R8"; exp_kind = wr ? 3'd4 : 3'd3; exp_ref = 1; end
        2'b10: begin rk = "R9"; exp_kind = wr ? 3'd4 : 3'd3; end
        2'b11: begin rk = "R10"; exp_kind = 3'd5; end
        default: rk = "R7";
      endcase
    end else if (st != 2'b00) rk = "R12";
    exp_fault = (exp_kind != 3'd0);
    @(negedge clk);
    req_valid = 1; req_addr = a; priv_mode = pm; err_level = el;
    req_write = wr; lk_status = st; lk_paddr = 32'h5A5A_0000 ^ a;
    #5;
    chk(rq, "lk_req", {31'd0, lk_req}, {31'd0, exp_map});
    chk(rk, "fault", {31'd0, fault}, {31'd0, exp_fault});
    chk(rk, "exc_kind", {29'd0, exc_kind}, {29'd0, exp_kind});
    chk(rk, "refill", {31'd0, refill}, {31'd0, exp_ref});
    if (!exp_fault) chk(rq, "phys_addr", phys_addr, exp_pa);
  endtask

  initial begin
    rst_n = 0; req_valid = 0; req_addr = 0; req_write = 0; priv_mode = 0;
    err_level = 0; lk_status = 0; lk_paddr = 0; cap_en = 0;
    ctx_base = 9'h1A3; cur_asid = 8'h5C;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #2;
    chk("R11", "reset bad_addr", bad_addr_q, 32'd0);
    chk("R11", "reset context", context_q, 32'd0);
    chk("R11", "reset entry_hi", entry_hi_q, 32'd0);

    for (int s = 0; s < 16; s++)
      for (int m = 0; m < 4; m++)
        for (int e = 0; e < 2; e++)
          for (int w = 0; w < 2; w++)
            for (int t = 0; t < 4; t++)
              sweep_one({s[3:0], 28'h2468ACE} ^ {4'h0, s[3:0], 24'h0}, m[1:0], e[0], w[0], t[1:0]);

    // R12: idle request stays quiet for any address and status
    for (int s = 0; s < 8; s++) begin
      @(negedge clk);
      req_valid = 0; req_addr = {s[2:0], 29'h0ABC}; priv_mode = 2'b10; lk_status = 2'b11;
      #5;
      chk("R12", "idle lk_req", {31'd0, lk_req}, 32'd0);
      chk("R12", "idle fault", {31'd0, fault}, 32'd0);
    end

    // R11: capture on fault with enable
    @(negedge clk);
    req_valid = 1; req_addr = 32'h9ABC_DEF4; priv_mode = 2'b10; req_write = 1;
    err_level = 0; cap_en = 1;
    @(negedge clk);
    chk("R11", "cap bad_addr", bad_addr_q, 32'h9ABC_DEF4);
    chk("R11", "cap context", context_q, {9'h1A3, 19'h4D5E6, 4'h0});
    chk("R11", "cap entry_hi", entry_hi_q, {19'h4D5E6, 5'h0, 8'h5C});
    // enable low: faulting request does not load
    cap_en = 0; req_addr = 32'hE123_4560; cur_asid = 8'h11;
    @(negedge clk);
    chk("R11", "hold bad_addr", bad_addr_q, 32'h9ABC_DEF4);
    chk("R11", "hold entry_hi", entry_hi_q, {19'h4D5E6, 5'h0, 8'h5C});
    // enable high but no fault: no load
    cap_en = 1; priv_mode = 2'b00; req_addr = 32'h8765_4320;
    @(negedge clk);
    chk("R11", "nofault bad_addr", bad_addr_q, 32'h9ABC_DEF4);
    chk("R11", "nofault context", context_q, {9'h1A3, 19'h4D5E6, 4'h0});
    // mapped miss captures with new identifier and base
    ctx_base = 9'h07F; req_addr = 32'hC001_E000; lk_status = 2'b01;
    @(negedge clk);
    chk("R11", "miss bad_addr", bad_addr_q, 32'hC001_E000);
    chk("R11", "miss context", context_q, {9'h07F, 19'h6000F, 4'h0});
    chk("R11", "miss entry_hi", entry_hi_q, {19'h6000F, 5'h0, 8'h11});
    cap_en = 0; req_valid = 0;
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin
        repeat (50000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule